// File: doc/BRIEF.md
# Endian-Selectable Bus Width Matcher

This block sits between a 36-bit memory word and a data port whose width is chosen by static configuration: 36, 18 or 9 bits. In the narrow widths, a 2-bit sub-counter picks which 18-bit half or 9-bit lane of the current word the port moves on each beat. Reads split the memory word into a run of narrow beats. Writes gather narrow beats into a 36-bit word, which is committed to memory only on the final beat of the word.

The endian input sets the beat order. In little endian the lowest half or lane goes first and the sub-counter counts up. In big endian the highest goes first and the sub-counter counts down. Only the first beat of a word needs the strobe. Later beats continue the sequence, and a beat after the final one starts the next word again without a strobe. The word-advance output tells the external address counter to step, and it pulses only on the final beat.

The block also formats a readback of the counter address for each width. In byte width this readback takes two beats.

Top module: `lane_width_adapter`

## Requirements
- R1: Configuration inputs are registered. A change on `cfg_narrow`, `cfg_byte` or `cfg_big` takes effect on the beat one clock after it is applied. The encoding is: `cfg_narrow`=0 selects 36-bit width; `cfg_narrow`=1 with `cfg_byte`=0 selects 18-bit width; both at 1 select 9-bit width.
- R2: In 36-bit width, a read beat drives the whole of `rd_word` on `port_out`. A write beat commits `wr_in` unchanged. Every beat is final. `cfg_big` has no effect.
- R3: In 18-bit width, little endian moves bits 17:0 first and bits 35:18 second, and big endian moves them in the opposite order. Each half appears on `port_out[17:0]`.
- R4: In 9-bit width, little endian moves lanes 8:0, 17:9, 26:18 and 35:27 in that order, and big endian moves them in the opposite order. Each lane appears on `port_out[8:0]`.
- R5: A beat with `beat_start` high always takes the first lane for the current endian order, even in the middle of a word. A beat without it takes the lane after the previous one, and wraps to the first lane of the next word after a final beat.
- R6: `word_adv` is high only during a beat on the final half or lane of a word. In the narrow widths, at least two beats separate two consecutive advances.
- R7: A narrow write asserts `mem_wr_en` only on the final beat. `mem_wr_data` then carries every half or lane written during that word, each in the position given in R3/R4.
- R8: `port_oe` is all ones for 36-bit, bits 17:0 for 18-bit and bits 8:0 for 9-bit during read beats and readback. It is all zero on write beats and idle cycles, so bits 35:9 are never driven in 9-bit width.
- R9: Readback (`rb_req`=1) puts `rb_addr` on bits 17:3 in 36-bit and 18-bit widths. In 18-bit width, bit 2 carries the pending half index.
- R10: In 9-bit width, readback takes two consecutive cycles. The first puts `rb_addr[14:6]` on bits 8:0. The second puts the pending lane index on bits 2:1 and `rb_addr[5:0]` on bits 8:3.
- R11: A readback cycle is not a beat. It does not advance the sub-counter, does not assert `word_adv` and does not write.
- R12: After reset, with no beat or readback requested, `port_oe`, `port_out`, `word_adv` and `mem_wr_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_narrow | input | 1 | Width match select (0 = 36-bit) |
| cfg_byte | input | 1 | Narrow size select (1 = 9-bit, 0 = 18-bit) |
| cfg_big | input | 1 | Endian select (1 = big endian) |
| beat_valid | input | 1 | A port beat occurs this cycle |
| beat_start | input | 1 | Strobe: this beat is the first of a word |
| beat_write | input | 1 | Beat is a write (else a read) |
| rb_req | input | 1 | Address readback cycle |
| rb_addr | input | 15 | Current word address for readback |
| rd_word | input | 36 | Memory word read at the current address |
| wr_in | input | 36 | Port write data, narrow widths use the low bits |
| port_out | output | 36 | Port output data |
| port_oe | output | 36 | Per-bit output enable for the port pins |
| word_adv | output | 1 | Final beat: step the word address counter |
| mem_wr_en | output | 1 | Commit a 36-bit word to memory |
| mem_wr_data | output | 36 | Word to commit |

## Verification
The properties assume that the configuration inputs stay unchanged while a word is in flight. Each property that depends on the width is qualified with the configuration being stable since the previous edge. The stimulus changes configuration only between words, and it inserts one idle cycle after each change, with one exception: the R1 check deliberately issues a beat in the same cycle as a change. Readback cycles are never presented together with a beat. The block ignores `beat_valid` during readback, and the bench keeps it low in those cycles.

// File: rtl/lwa_pkg.sv
package lwa_pkg;

   typedef enum logic [1:0] {
      MODE_W36 = 2'd0,
      MODE_W18 = 2'd1,
      MODE_W9  = 2'd2
   } width_mode_e;

   function automatic width_mode_e decode_mode(input logic narrow, input logic byte_sel);
      if (!narrow)
         return MODE_W36;
      else if (byte_sel)
         return MODE_W9;
      else
         return MODE_W18;
   endfunction

endpackage

// File: rtl/lwa_cfg_reg.sv
module lwa_cfg_reg
   import lwa_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_narrow,
   input  logic        cfg_byte,
   input  logic        cfg_big,
   output width_mode_e mode,
   output logic        big
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_W36;
         big  <= 1'b0;
      end else begin
         mode <= decode_mode(cfg_narrow, cfg_byte);
         big  <= cfg_big;
      end
   end

endmodule

// File: rtl/lwa_subcnt.sv
module lwa_subcnt
   import lwa_pkg::*;
#(
   parameter int IDX_W = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  width_mode_e      mode,
   input  logic             big,
   input  logic             beat,
   input  logic             start,
   output logic [IDX_W-1:0] cur,
   output logic [IDX_W-1:0] pend,
   output logic             is_last
);

   localparam logic [IDX_W-1:0] IDX_MAX = '1;
   localparam logic [IDX_W-1:0] ONE     = IDX_W'(1);

   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] first_idx;
   logic [IDX_W-1:0] nxt;

   always_comb begin
      case (mode)
         MODE_W9:  last_idx = IDX_MAX;
         MODE_W18: last_idx = ONE;
         default:  last_idx = '0;
      endcase
      first_idx = big ? last_idx : '0;
      cur       = start ? first_idx : pend;
      if (mode == MODE_W36)
         is_last = 1'b1;
      else if (big)
         is_last = (cur == '0);
      else
         is_last = (cur == last_idx);
      if (big)
         nxt = (cur == '0) ? last_idx : cur - ONE;
      else
         nxt = (cur == last_idx) ? '0 : cur + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= '0;
      else if (beat)
         pend <= nxt;
   end

endmodule

// File: rtl/lwa_datapath.sv
module lwa_datapath
   import lwa_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter int ADDR_W = 15,
   localparam int DATA_W = LANE_W * LANES,
   localparam int HALF_W = DATA_W / 2,
   localparam int IDX_W  = $clog2(LANES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  width_mode_e       mode,
   input  logic [IDX_W-1:0]  cur,
   input  logic [IDX_W-1:0]  pend,
   input  logic              beat,
   input  logic              is_last,
   input  logic              write,
   input  logic              rb_req,
   input  logic [ADDR_W-1:0] rb_addr,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] wr_in,
   output logic [DATA_W-1:0] port_out,
   output logic [DATA_W-1:0] port_oe,
   output logic              mem_wr_en,
   output logic [DATA_W-1:0] mem_wr_data
);

   localparam int RB_OFS = 3;
   localparam int LOW_A  = LANE_W - RB_OFS;
   localparam logic [DATA_W-1:0] MASK_ALL  = '1;
   localparam logic [DATA_W-1:0] MASK_HALF = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
   localparam logic [DATA_W-1:0] MASK_LANE = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

   logic [LANE_W-1:0] lane_rd [LANES];
   logic [HALF_W-1:0] half_rd [2];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_rd[g] = rd_word[g*LANE_W +: LANE_W];
   end
   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half_rd[h] = rd_word[h*HALF_W +: HALF_W];
   end

   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] merged;
   logic              rb_ph;
   logic [DATA_W-1:0] rb_wide;
   logic [DATA_W-1:0] rb_word;
   logic [DATA_W-1:0] rb_hi;
   logic [DATA_W-1:0] rb_lo;

   always_comb begin
      merged = acc;
      case (mode)
         MODE_W18: merged[int'(cur[0])*HALF_W +: HALF_W] = wr_in[HALF_W-1:0];
         MODE_W9:  merged[int'(cur)*LANE_W +: LANE_W]    = wr_in[LANE_W-1:0];
         default:  merged = wr_in;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (beat && write)
         acc <= merged;
   end

   assign mem_wr_en   = beat && write && is_last;
   assign mem_wr_data = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rb_ph <= 1'b0;
      else if (rb_req && mode == MODE_W9)
         rb_ph <= ~rb_ph;
      else
         rb_ph <= 1'b0;
   end

   assign rb_wide = DATA_W'(rb_addr) << RB_OFS;
   assign rb_word = rb_wide | (DATA_W'(pend[0]) << (RB_OFS - 1));
   assign rb_hi   = DATA_W'(rb_addr[ADDR_W-1:LOW_A]);
   assign rb_lo   = DATA_W'({rb_addr[LOW_A-1:0], pend, 1'b0});

   always_comb begin
      port_out = '0;
      port_oe  = '0;
      if (rb_req) begin
         case (mode)
            MODE_W18: begin port_out = rb_word; port_oe = MASK_HALF; end
            MODE_W9:  begin port_out = rb_ph ? rb_lo : rb_hi; port_oe = MASK_LANE; end
            default:  begin port_out = rb_wide; port_oe = MASK_ALL; end
         endcase
      end else if (beat && !write) begin
         case (mode)
            MODE_W18: begin port_out = DATA_W'(half_rd[cur[0]]); port_oe = MASK_HALF; end
            MODE_W9:  begin port_out = DATA_W'(lane_rd[cur]); port_oe = MASK_LANE; end
            default:  begin port_out = rd_word; port_oe = MASK_ALL; end
         endcase
      end
   end

endmodule

// File: rtl/lane_width_adapter.sv
module lane_width_adapter
   import lwa_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   parameter int ADDR_W = 15,
   localparam int DATA_W = LANE_W * LANES,
   localparam int IDX_W  = $clog2(LANES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_narrow,
   input  logic              cfg_byte,
   input  logic              cfg_big,
   input  logic              beat_valid,
   input  logic              beat_start,
   input  logic              beat_write,
   input  logic              rb_req,
   input  logic [ADDR_W-1:0] rb_addr,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] wr_in,
   output logic [DATA_W-1:0] port_out,
   output logic [DATA_W-1:0] port_oe,
   output logic              word_adv,
   output logic              mem_wr_en,
   output logic [DATA_W-1:0] mem_wr_data
);

   if (LANES != 4) begin : g_bad_lanes
      $error("lane_width_adapter: LANES must be 4");
   end
   if (ADDR_W - (LANE_W - 3) > LANE_W) begin : g_bad_rb9
      $error("lane_width_adapter: upper readback field exceeds one lane");
   end
   if (ADDR_W + 3 > DATA_W / 2) begin : g_bad_rb18
      $error("lane_width_adapter: readback field exceeds one half word");
   end

   width_mode_e      mode;
   logic             big;
   logic             beat;
   logic [IDX_W-1:0] cur;
   logic [IDX_W-1:0] pend;
   logic             is_last;

   assign beat     = beat_valid && !rb_req;
   assign word_adv = beat && is_last;

   lwa_cfg_reg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_narrow (cfg_narrow),
      .cfg_byte   (cfg_byte),
      .cfg_big    (cfg_big),
      .mode       (mode),
      .big        (big)
   );

   lwa_subcnt #(.IDX_W(IDX_W)) u_sub (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .big     (big),
      .beat    (beat),
      .start   (beat_start),
      .cur     (cur),
      .pend    (pend),
      .is_last (is_last)
   );

   lwa_datapath #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .cur         (cur),
      .pend        (pend),
      .beat        (beat),
      .is_last     (is_last),
      .write       (beat_write),
      .rb_req      (rb_req),
      .rb_addr     (rb_addr),
      .rd_word     (rd_word),
      .wr_in       (wr_in),
      .port_out    (port_out),
      .port_oe     (port_oe),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_data (mem_wr_data)
   );

endmodule

// File: rtl/lwa_chk.sv
module lwa_chk #(
   parameter int LANE_W = 9,
   parameter int DATA_W = 36
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_narrow,
   input logic              cfg_byte,
   input logic              cfg_big,
   input logic              beat_valid,
   input logic              beat_start,
   input logic              rb_req,
   input logic [DATA_W-1:0] port_oe,
   input logic              word_adv,
   input logic              mem_wr_en
);

   // R7
   commit_on_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> word_adv);

   // R8
   quiet_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (port_oe == '0));

   // R8
   byte_upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_narrow && cfg_byte && $stable(cfg_narrow) && $stable(cfg_byte))
         |-> (port_oe[DATA_W-1:LANE_W] == '0));

   // R11
   readback_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_req |-> (!word_adv && !mem_wr_en));

   // R2
   wide_every_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !rb_req && !cfg_narrow && $stable(cfg_narrow)) |-> word_adv);

   // R6
   narrow_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_adv && cfg_narrow && $stable(cfg_narrow) && $stable(cfg_byte) && $stable(cfg_big))
         |=> (!(beat_valid && !beat_start && !rb_req && $stable(cfg_narrow)
                && $stable(cfg_byte) && $stable(cfg_big)) || !word_adv));

endmodule

bind lane_width_adapter lwa_chk #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_narrow (cfg_narrow),
   .cfg_byte   (cfg_byte),
   .cfg_big    (cfg_big),
   .beat_valid (beat_valid),
   .beat_start (beat_start),
   .rb_req     (rb_req),
   .port_oe    (port_oe),
   .word_adv   (word_adv),
   .mem_wr_en  (mem_wr_en)
);

// File: tb/lane_width_adapter_test.sv
module lane_width_adapter_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [35:0] RW = 36'h9A5C3E1F7;
   localparam logic [14:0] RBA = 15'h5A3C;
   localparam int NVEC = 19;
   // fields: mode[6:5] (0=36,1=18,2=9), big[4], start[3], lane[2:1], adv[0]
   localparam logic [6:0] VEC [NVEC] = '{
      {2'd0,1'b0,1'b1,2'd0,1'b1}, {2'd0,1'b1,1'b0,2'd0,1'b1},
      {2'd1,1'b0,1'b1,2'd0,1'b0}, {2'd1,1'b0,1'b0,2'd1,1'b1},
      {2'd1,1'b0,1'b0,2'd0,1'b0}, {2'd1,1'b0,1'b0,2'd1,1'b1},
      {2'd1,1'b1,1'b1,2'd1,1'b0}, {2'd1,1'b1,1'b0,2'd0,1'b1},
      {2'd1,1'b1,1'b0,2'd1,1'b0},
      {2'd2,1'b0,1'b1,2'd0,1'b0}, {2'd2,1'b0,1'b0,2'd1,1'b0},
      {2'd2,1'b0,1'b0,2'd2,1'b0}, {2'd2,1'b0,1'b0,2'd3,1'b1},
      {2'd2,1'b0,1'b1,2'd0,1'b0}, {2'd2,1'b0,1'b1,2'd0,1'b0},
      {2'd2,1'b1,1'b1,2'd3,1'b0}, {2'd2,1'b1,1'b0,2'd2,1'b0},
      {2'd2,1'b1,1'b0,2'd1,1'b0}, {2'd2,1'b1,1'b0,2'd0,1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_narrow = 1'b0, cfg_byte = 1'b0, cfg_big = 1'b0;
   logic        beat_valid = 1'b0, beat_start = 1'b0, beat_write = 1'b0, rb_req = 1'b0;
   logic [14:0] rb_addr = RBA;
   logic [35:0] rd_word = RW;
   logic [35:0] wr_in = '0;
   logic [35:0] port_out, port_oe, mem_wr_data;
   logic        word_adv, mem_wr_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_width_adapter uut (
      .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte),
      .cfg_big(cfg_big), .beat_valid(beat_valid), .beat_start(beat_start),
      .beat_write(beat_write), .rb_req(rb_req), .rb_addr(rb_addr),
      .rd_word(rd_word), .wr_in(wr_in), .port_out(port_out), .port_oe(port_oe),
      .word_adv(word_adv), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
   );

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_cfg(input int m, input logic b);
      cfg_narrow = (m != 0);
      cfg_byte   = (m == 2);
      cfg_big    = b;
   endtask

   task automatic idle();
      beat_valid = 1'b0; beat_start = 1'b0; beat_write = 1'b0; rb_req = 1'b0;
   endtask

   function automatic logic [35:0] exp_read(input int m, input int lane);
      if (m == 0) return RW;
      else if (m == 1) return (RW >> (lane*18)) & 36'h3FFFF;
      else return (RW >> (lane*9)) & 36'h1FF;
   endfunction

   function automatic logic [35:0] exp_oe(input int m);
      if (m == 0) return '1;
      else if (m == 1) return 36'h3FFFF;
      else return 36'h1FF;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int pm;
      logic pb;
      logic [35:0] expw;
      idle();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      #1;
      // R12 reset state
      check("R12 oe", port_oe, '0);
      check("R12 out", port_out, '0);
      check("R12 adv", {35'b0, word_adv}, 36'd0);
      check("R12 wr_en", {35'b0, mem_wr_en}, 36'd0);

      // table of read beats
      pm = 0; pb = 1'b0;
      for (int i = 0; i < NVEC; i++) begin
         int m, lane;
         logic b, st, adv;
         string tag;
         m = int'(VEC[i][6:5]); b = VEC[i][4]; st = VEC[i][3];
         lane = int'(VEC[i][2:1]); adv = VEC[i][0];
         tag = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
         tick();
         if (m != pm || b != pb) begin
            idle();
            set_cfg(m, b);
            tick();
            pm = m; pb = b;
         end
         beat_valid = 1'b1; beat_start = st; beat_write = 1'b0;
         #1;
         check({tag, " R5 data"}, port_out, exp_read(m, lane));
         check("R8 oe", port_oe, exp_oe(m));
         check("R6 adv", {35'b0, word_adv}, {35'b0, adv});
      end

      // R7 9-bit little-endian write assembly
      tick(); idle(); set_cfg(2, 1'b0); tick();
      beat_valid = 1'b1; beat_write = 1'b1; beat_start = 1'b1; wr_in = 36'h0AA;
      #1; check("R7 no early commit", {35'b0, mem_wr_en}, 36'd0);
      check("R8 oe on write", port_oe, '0);
      tick(); beat_start = 1'b0; wr_in = 36'h055;
      #1; check("R7 no early commit", {35'b0, mem_wr_en}, 36'd0);
      tick(); wr_in = 36'h133;
      #1; check("R7 no early commit", {35'b0, mem_wr_en}, 36'd0);
      tick(); wr_in = 36'h1CC;
      expw = (36'h1CC << 27) | (36'h133 << 18) | (36'h055 << 9) | 36'h0AA;
      #1; check("R7 commit", {35'b0, mem_wr_en}, 36'd1);
      check("R7 word", mem_wr_data, expw);

      // R7 R3 18-bit big-endian write
      tick(); idle(); set_cfg(1, 1'b1); tick();
      beat_valid = 1'b1; beat_write = 1'b1; beat_start = 1'b1; wr_in = 36'h15A5A;
      #1; check("R7 no early commit", {35'b0, mem_wr_en}, 36'd0);
      tick(); beat_start = 1'b0; wr_in = 36'h0F0F0;
      #1; check("R7 commit", {35'b0, mem_wr_en}, 36'd1);
      check("R3 R7 word", mem_wr_data, (36'h15A5A << 18) | 36'h0F0F0);

      // R2 36-bit write, endian ignored
      tick(); idle(); set_cfg(0, 1'b1); tick();
      beat_valid = 1'b1; beat_write = 1'b1; beat_start = 1'b0; wr_in = 36'hFEDCBA987;
      #1; check("R2 commit", {35'b0, mem_wr_en}, 36'd1);
      check("R2 word", mem_wr_data, 36'hFEDCBA987);

      // R9 36-bit readback
      tick(); idle(); set_cfg(0, 1'b0); tick();
      rb_req = 1'b1;
      #1; check("R9 rb36", port_out, 36'(RBA) << 3);
      check("R9 rb36 oe", port_oe, '1);

      // R9 R11 18-bit readback between beats
      tick(); idle(); set_cfg(1, 1'b0); tick();
      beat_valid = 1'b1; beat_start = 1'b1;
      tick(); idle(); rb_req = 1'b1;
      #1; check("R9 rb18", port_out, (36'(RBA) << 3) | 36'h4);
      check("R11 rb adv", {35'b0, word_adv}, 36'd0);
      tick(); idle(); beat_valid = 1'b1;
      #1; check("R11 resume data", port_out, exp_read(1, 1));
      check("R11 resume adv", {35'b0, word_adv}, 36'd1);

      // R10 R11 9-bit two-beat readback
      tick(); idle(); set_cfg(2, 1'b0); tick();
      beat_valid = 1'b1; beat_start = 1'b1;
      tick(); idle(); rb_req = 1'b1;
      #1; check("R10 rb9 first", port_out, 36'(RBA >> 6));
      check("R10 rb9 oe", port_oe, 36'h1FF);
      tick();
      #1; check("R10 rb9 second", port_out, (36'(RBA & 15'h3F) << 3) | 36'h2);
      tick(); idle(); beat_valid = 1'b1;
      #1; check("R11 resume lane", port_out, exp_read(2, 1));

      // R1 configuration takes effect one cycle later
      tick(); idle(); set_cfg(0, 1'b0); beat_valid = 1'b1; beat_start = 1'b1;
      #1; check("R1 old width", port_oe, 36'h1FF);
      tick();
      #1; check("R1 new width", port_oe, '1);
      check("R1 new data", port_out, RW);

      tick(); idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule